// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is the slave-side receiver of a three-pair serial audio input. It runs directly on the incoming serial bit clock and decodes left/right audio for three stereo pairs. The samples arrive either on three data lanes, one pair per lane, or time-multiplexed onto lane 0. A 3-bit format code picks the framing convention. A 2-bit length code picks how many bits of each slot carry the sample. Every sample is two's complement and arrives MSB first.

After each complete frame the block presents six 24-bit samples at once, ordered pair 0 left, pair 0 right, pair 1 left, and so on. Shorter words sit in the upper bits with zero fill below, so the sign is preserved. Along with the samples it raises a one-cycle frame-valid strobe. The word-select line is sampled on the same edge as the data. The counting of bit positions restarts at each framing edge, so the receiver locks to the stream without any setup sequence.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `frame_valid` is 0 and all of `samples` is 0.
- R2: Format 000 (I2S): `ws` low carries the left word, `ws` high the right word. The MSB is on the second bit clock after a `ws` change, at position 1, where position 0 is the bit clock that shows the change.
- R3: Format 011 (left-justified): `ws` high carries the left word. The MSB is at position 0, the same bit clock as the `ws` change.
- R4: Format 001 (right-justified): `ws` high carries the left word. Each half is 32 bit clocks and the LSB is at position 31, so the MSB is at position 32 minus the word length.
- R5: Format 010 (DSP): every rising edge of `ws` starts a word, and the MSB is at position 1. Words alternate left, right, left and so on. After reset the first word is always left.
- R6: Format 100 (packed): a frame is 8 slots of 32 bit clocks on lane 0 only, starting at a falling edge of `ws`. Slots 0-2 carry left of pairs 0-2, slots 4-6 carry right of pairs 0-2, and slots 3 and 7 are empty. The MSB is at slot offset 1. Lanes 1 and 2 have no effect.
- R7: Length code 00 = 24, 01 = 20, 10 = 16 bits, and 11 is taken as 24. A sample of N bits is output as its N bits in the top of the 24-bit field with 24-N zero bits below.
- R8: `frame_valid` is a one-cycle pulse after the last right sample of a frame whose left samples were also captured since the last publish. `samples` changes only together with it. No frame is reported before the first framing edge after reset.
- R9: Format codes 101, 110 and 111 capture nothing: `frame_valid` stays 0 and `samples` holds.
- R10: In DSP and packed formats `ws` and `sd` are sampled on the falling edge of `sck`. In the other formats they are sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial bit clock; the block's only clock |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word select / frame sync |
| sd | input | 3 | Serial data lanes, one per stereo pair (lane 0 only in packed format) |
| fmt | input | 3 | Framing format code |
| wlen | input | 2 | Word length code |
| samples | output | 144 | Six 24-bit samples, sample i at bits 24*i+23:24*i, order L0,R0,L1,R1,L2,R2 |
| frame_valid | output | 1 | One-cycle strobe when a new frame is on `samples` |

## Verification
Each format is driven with back-to-back frames of random words and with a frame of extremes: largest positive, most negative, -1, +1, zero and an alternating pattern. Together these separate a wrong MSB offset, a swapped left/right polarity and a lost sign bit. The lengths 16, 20, 24 and the reserved code are mixed across formats to show the zero-filled low bits. DSP words are driven with data valid only around the falling edge, which catches a capture on the wrong edge. A reset after a lone DSP word shows that the alternation restarts on left. Packed frames carry noise on the unused lanes. A reserved format with toggling `ws` must produce no strobe.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    FMT_I2S = 3'd0,
    FMT_RJ  = 3'd1,
    FMT_DSP = 3'd2,
    FMT_LJ  = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  // Number of meaningful bits per word for a given length code.
  function automatic int data_bits(input int full_w, input logic [1:0] code);
    case (code)
      2'b01:   return full_w - 4;
      2'b10:   return full_w - 8;
      default: return full_w;
    endcase
  endfunction

  // Formats whose data is captured on the falling clock edge.
  function automatic logic falling_capture(input logic [2:0] code);
    return (code == FMT_DSP) || (code == FMT_TDM);
  endfunction

endpackage

// File: rtl/sar_edge_track.sv
module sar_edge_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws_i,
  input  logic [2:0]       fmt_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             active_o
);
  import sar_pkg::*;

  logic             ws_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             fall;
  logic             start;

  always_comb begin
    rise = ws_i & ~ws_q;
    fall = ~ws_i & ws_q;
    case (fmt_i)
      FMT_I2S, FMT_LJ, FMT_RJ: start = rise | fall;
      FMT_DSP:                 start = rise;
      FMT_TDM:                 start = fall;
      default:                 start = 1'b0;
    endcase
    if (start)
      pos_o = '0;
    else if (&cnt_q)
      pos_o = cnt_q;
    else
      pos_o = cnt_q + 1'b1;
    active_o = armed_q | start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      ws_q    <= ws_i;
      armed_q <= armed_q | start;
      cnt_q   <= pos_o;
    end
  end

endmodule

// File: rtl/sar_lane_shift.sv
module sar_lane_shift #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] word_o
);
  import sar_pkg::*;

  logic [SAMPLE_W-1:0] sh_q;
  logic [SAMPLE_W-1:0] full;
  int                  nb;

  always_comb begin
    nb     = data_bits(SAMPLE_W, wlen_i);
    full   = {sh_q[SAMPLE_W-2:0], bit_i};
    word_o = full << (SAMPLE_W - nb);
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= full;
  end

endmodule

// File: rtl/sar_slot_decode.sv
module sar_slot_decode #(
  parameter int SAMPLE_W   = 24,
  parameter int LANES      = 3,
  parameter int HALF_BCLKS = 32,
  parameter int SLOT_BCLKS = 32,
  parameter int SLOTS      = 8,
  parameter int CNT_W      = 8,
  parameter int PAIR_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              active_i,
  input  logic              ws_i,
  output logic              commit_o,
  output logic              side_o,
  output logic              packed_o,
  output logic [PAIR_W-1:0] pair_o
);
  import sar_pkg::*;

  localparam int HALF_SLOTS = SLOTS / 2;
  localparam int SLOT_SH    = $clog2(SLOT_BCLKS);

  logic alt_q;
  int   p;
  int   nb;
  int   slot;
  int   off;
  int   sub;

  always_comb begin
    p        = int'(pos_i);
    nb       = data_bits(SAMPLE_W, wlen_i);
    slot     = p >> SLOT_SH;
    off      = p & (SLOT_BCLKS - 1);
    sub      = slot % HALF_SLOTS;
    commit_o = 1'b0;
    side_o   = 1'b0;
    packed_o = 1'b0;
    pair_o   = '0;
    case (fmt_i)
      FMT_I2S: begin
        commit_o = active_i && (p == nb);
        side_o   = ws_i;
      end
      FMT_LJ: begin
        commit_o = active_i && (p == nb - 1);
        side_o   = ~ws_i;
      end
      FMT_RJ: begin
        commit_o = active_i && (p == HALF_BCLKS - 1);
        side_o   = ~ws_i;
      end
      FMT_DSP: begin
        commit_o = active_i && (p == nb);
        side_o   = alt_q;
      end
      FMT_TDM: begin
        packed_o = 1'b1;
        commit_o = active_i && (off == nb) && (sub < LANES);
        side_o   = (slot >= HALF_SLOTS);
        pair_o   = PAIR_W'(sub);
      end
      default: ;
    endcase
  end

  // Left/right alternation for frame-sync framing.
  always_ff @(posedge clk) begin
    if (rst)
      alt_q <= 1'b0;
    else if ((fmt_i == FMT_DSP) && commit_o)
      alt_q <= ~alt_q;
  end

endmodule

// File: rtl/sar_frame_assemble.sv
module sar_frame_assemble #(
  parameter int SAMPLE_W = 24,
  parameter int LANES    = 3,
  parameter int PAIR_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        commit_i,
  input  logic                        side_i,
  input  logic                        packed_i,
  input  logic [PAIR_W-1:0]           pair_i,
  input  logic [LANES*SAMPLE_W-1:0]   words_i,
  output logic [2*LANES*SAMPLE_W-1:0] samples_o,
  output logic                        frame_valid_o
);

  localparam int NCH = 2 * LANES;

  logic [SAMPLE_W-1:0] stg_q [NCH];
  logic [SAMPLE_W-1:0] stg_n [NCH];
  logic                left_seen_q;
  logic                publish;
  logic [NCH*SAMPLE_W-1:0] frame_n;

  always_comb begin
    for (int i = 0; i < NCH; i++) stg_n[i] = stg_q[i];
    if (commit_i) begin
      if (packed_i) begin
        stg_n[2*int'(pair_i) + int'(side_i)] = words_i[0 +: SAMPLE_W];
      end else begin
        for (int l = 0; l < LANES; l++)
          stg_n[2*l + int'(side_i)] = words_i[l*SAMPLE_W +: SAMPLE_W];
      end
    end
    for (int i = 0; i < NCH; i++) frame_n[i*SAMPLE_W +: SAMPLE_W] = stg_n[i];
    publish = commit_i && side_i && left_seen_q &&
              (!packed_i || (int'(pair_i) == LANES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) stg_q[i] <= '0;
      left_seen_q   <= 1'b0;
      samples_o     <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) stg_q[i] <= stg_n[i];
      frame_valid_o <= publish;
      if (publish) begin
        samples_o   <= frame_n;
        left_seen_q <= 1'b0;
      end else if (commit_i && !side_i) begin
        left_seen_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W   = 24,
  parameter int LANES      = 3,
  parameter int HALF_BCLKS = 32,
  parameter int SLOT_BCLKS = 32,
  parameter int SLOTS      = 8
) (
  input  logic                        sck,
  input  logic                        rst,
  input  logic                        ws,
  input  logic [LANES-1:0]            sd,
  input  logic [2:0]                  fmt,
  input  logic [1:0]                  wlen,
  output logic [2*LANES*SAMPLE_W-1:0] samples,
  output logic                        frame_valid
);
  import sar_pkg::*;

  localparam int FRAME_MAX = (SLOTS * SLOT_BCLKS > 2 * HALF_BCLKS) ?
                             SLOTS * SLOT_BCLKS : 2 * HALF_BCLKS;
  localparam int CNT_W     = $clog2(FRAME_MAX);
  localparam int PAIR_W    = (LANES > 1) ? $clog2(LANES) : 1;

  // Falling-edge capture for frame-sync and packed formats.
  logic             ws_n;
  logic [LANES-1:0] sd_n;
  logic             ws_s;
  logic [LANES-1:0] sd_s;

  always_ff @(negedge sck) begin
    if (rst) begin
      ws_n <= 1'b0;
      sd_n <= '0;
    end else begin
      ws_n <= ws;
      sd_n <= sd;
    end
  end

  always_comb begin
    if (falling_capture(fmt)) begin
      ws_s = ws_n;
      sd_s = sd_n;
    end else begin
      ws_s = ws;
      sd_s = sd;
    end
  end

  logic [CNT_W-1:0]          pos;
  logic                      active;
  logic                      commit;
  logic                      side;
  logic                      packed_sel;
  logic [PAIR_W-1:0]         pair;
  logic [LANES*SAMPLE_W-1:0] words;

  sar_edge_track #(.CNT_W(CNT_W)) u_track (
    .clk      (sck),
    .rst      (rst),
    .ws_i     (ws_s),
    .fmt_i    (fmt),
    .pos_o    (pos),
    .active_o (active)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sar_lane_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk    (sck),
      .rst    (rst),
      .bit_i  (sd_s[g]),
      .wlen_i (wlen),
      .word_o (words[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  sar_slot_decode #(
    .SAMPLE_W   (SAMPLE_W),
    .LANES      (LANES),
    .HALF_BCLKS (HALF_BCLKS),
    .SLOT_BCLKS (SLOT_BCLKS),
    .SLOTS      (SLOTS),
    .CNT_W      (CNT_W),
    .PAIR_W     (PAIR_W)
  ) u_decode (
    .clk      (sck),
    .rst      (rst),
    .fmt_i    (fmt),
    .wlen_i   (wlen),
    .pos_i    (pos),
    .active_i (active),
    .ws_i     (ws_s),
    .commit_o (commit),
    .side_o   (side),
    .packed_o (packed_sel),
    .pair_o   (pair)
  );

  sar_frame_assemble #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES),
    .PAIR_W   (PAIR_W)
  ) u_assemble (
    .clk           (sck),
    .rst           (rst),
    .commit_i      (commit),
    .side_i        (side),
    .packed_i      (packed_sel),
    .pair_i        (pair),
    .words_i       (words),
    .samples_o     (samples),
    .frame_valid_o (frame_valid)
  );

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int SAMPLE_W = 24,
  parameter int LANES    = 3
) (
  input logic                        sck,
  input logic                        rst,
  input logic [2:0]                  fmt,
  input logic [1:0]                  wlen,
  input logic [2*LANES*SAMPLE_W-1:0] samples,
  input logic                        frame_valid
);

  localparam int TOP_R = (2 * LANES - 1) * SAMPLE_W;

  // R1: outputs clear right after reset
  a_r1_reset_clears: assert property (@(posedge sck) disable iff (rst)
    $past(rst) |-> (!frame_valid && samples == '0));

  // R8: strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge sck) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R8: samples move only with the strobe
  a_r8_hold_between: assert property (@(posedge sck) disable iff (rst)
    !frame_valid |-> $stable(samples));

  // R9: reserved formats never publish
  a_r9_reserved_silent: assert property (@(posedge sck) disable iff (rst)
    (fmt > 3'd4) |=> !frame_valid);

  // R7: 16-bit words leave the low byte of the final right sample zero
  a_r7_short_zero_fill: assert property (@(posedge sck) disable iff (rst)
    (frame_valid && wlen == 2'b10 && $past(wlen) == 2'b10)
      |-> (samples[TOP_R +: 8] == 8'h00));

endmodule

bind serial_audio_rx sar_checker #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_chk (
  .sck         (sck),
  .rst         (rst),
  .fmt         (fmt),
  .wlen        (wlen),
  .samples     (samples),
  .frame_valid (frame_valid)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  localparam int CLK_PERIOD = 10;
  localparam int SW  = 24;
  localparam int NCH = 6;

  logic           sck = 1'b0;
  logic           rst = 1'b1;
  logic           ws  = 1'b0;
  logic [2:0]     sd  = '0;
  logic [2:0]     fmt = '0;
  logic [1:0]     wlen = '0;
  logic [143:0]   samples;
  logic           frame_valid;

  serial_audio_rx dut (
    .sck(sck), .rst(rst), .ws(ws), .sd(sd), .fmt(fmt), .wlen(wlen),
    .samples(samples), .frame_valid(frame_valid)
  );

  always #(CLK_PERIOD/2) sck = ~sck;

  int n_cmp = 0;
  int n_bad = 0;
  int frames_seen = 0;
  int frames_pushed = 0;
  logic [143:0] exp_q[$];
  string        tag_q[$];
  logic [23:0]  cur [NCH];

  task automatic check(input bit ok, input string tag,
                       input logic [143:0] act, input logic [143:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pop and compare on each strobe.
  always @(negedge sck) begin : monitor
    logic [143:0] e;
    string t;
    if (!rst && frame_valid) begin
      frames_seen++;
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R8 unexpected frame actual=%h expected=none", samples);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(samples === e, t, samples, e);
      end
    end
  end

  function automatic logic [23:0] align(input logic [23:0] v, input int nb);
    return v << (SW - nb);
  endfunction

  task automatic push_expect(input int nb, input string tag);
    logic [143:0] e;
    for (int i = 0; i < NCH; i++) e[24*i +: 24] = align(cur[i], nb);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    frames_pushed++;
  endtask

  task automatic set_vals(input int kind, input int nb);
    if (kind == 0) begin
      for (int i = 0; i < NCH; i++) cur[i] = 24'($urandom);
    end else begin
      cur[0] = 24'((1 << (nb - 1)) - 1);
      cur[1] = 24'(1 << (nb - 1));
      cur[2] = 24'hFFFFFF;
      cur[3] = 24'h000001;
      cur[4] = 24'h000000;
      cur[5] = 24'h5A5A5A;
    end
  endtask

  task automatic send_bit(input logic w, input logic [2:0] d, input bit glitch);
    @(posedge sck);
    #1;
    ws = w;
    sd = d;
    if (glitch) begin
      @(negedge sck);
      #1;
      sd = ~d;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(ws, 3'b000, 1'b0);
  endtask

  task automatic do_reset(input logic [2:0] f, input logic [1:0] w);
    @(posedge sck);
    #1;
    rst = 1'b1;
    ws  = 1'b0;
    sd  = '0;
    repeat (3) @(posedge sck);
    #1;
    fmt  = f;
    wlen = w;
    @(negedge sck);
    check(frame_valid == 1'b0 && samples == '0, "R1 reset state",
          {143'd0, frame_valid} | samples, '0);
    @(posedge sck);
    #1;
    rst = 1'b0;
  endtask

  // Two-half frame for I2S / LJ / RJ (and reserved-format stimulus).
  task automatic stereo_frame(input int nb, input bit expect_it, input string tag);
    logic [2:0] d;
    logic       w;
    int         idx;
    if (expect_it) push_expect(nb, tag);
    for (int h = 0; h < 2; h++) begin
      w = (fmt == 3'd0) ? logic'(h) : logic'(1 - h);
      for (int p = 0; p < 32; p++) begin
        for (int l = 0; l < 3; l++) begin
          idx = -1;
          if (fmt == 3'd0 && p >= 1 && p <= nb) idx = nb - p;
          else if (fmt == 3'd1 && p >= 32 - nb) idx = 31 - p;
          else if (fmt != 3'd0 && fmt != 3'd1 && p < nb) idx = nb - 1 - p;
          d[l] = (idx >= 0) ? cur[2*l + h][idx] : 1'b0;
        end
        send_bit(w, d, 1'b0);
      end
    end
  endtask

  task automatic dsp_word(input int nb, input int side, input bit glitch);
    logic [2:0] d;
    int         idx;
    for (int p = 0; p < 32; p++) begin
      for (int l = 0; l < 3; l++) begin
        idx = (p >= 1 && p <= nb) ? nb - p : -1;
        d[l] = (idx >= 0) ? cur[2*l + side][idx] : 1'b0;
      end
      send_bit(p < 2, d, glitch);
    end
  endtask

  task automatic dsp_frame(input int nb, input bit expect_it, input string tag);
    if (expect_it) push_expect(nb, tag);
    dsp_word(nb, 0, 1'b1);
    dsp_word(nb, 1, 1'b1);
  endtask

  task automatic tdm_frame(input int nb, input bit expect_it, input string tag);
    logic [2:0] d;
    int         ch;
    int         idx;
    if (expect_it) push_expect(nb, tag);
    for (int s = 0; s < 8; s++) begin
      ch = (s < 3) ? 2*s : (s >= 4 && s < 7) ? 2*(s-4) + 1 : -1;
      for (int o = 0; o < 32; o++) begin
        idx = (ch >= 0 && o >= 1 && o <= nb) ? nb - o : -1;
        d[0] = (idx >= 0) ? cur[ch][idx] : 1'b0;
        d[2:1] = 2'($urandom);
        send_bit(s >= 4, d, 1'b0);
      end
    end
  endtask

  task automatic drain(input string tag);
    idle(6);
    check(exp_q.size() == 0, tag, 144'(exp_q.size()), '0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin : stimulus
    // R2: I2S, 24 bits; first frame lacks a leading edge (R8)
    do_reset(3'd0, 2'b00);
    set_vals(0, 24); stereo_frame(24, 1'b0, "");
    set_vals(0, 24); stereo_frame(24, 1'b1, "R2 I2S 24-bit random");
    set_vals(1, 24); stereo_frame(24, 1'b1, "R2 I2S 24-bit extremes");
    set_vals(0, 24); stereo_frame(24, 1'b1, "R2 I2S 24-bit random b");
    drain("R8 I2S frames all reported");

    // R2 R7: I2S 20 bits
    do_reset(3'd0, 2'b01);
    set_vals(0, 20); stereo_frame(20, 1'b0, "");
    set_vals(1, 20); stereo_frame(20, 1'b1, "R2 R7 I2S 20-bit extremes");
    drain("R8 I2S 20-bit drained");

    // R3 R7: left-justified 16 bits
    do_reset(3'd3, 2'b10);
    set_vals(1, 16); stereo_frame(16, 1'b1, "R3 R7 LJ 16-bit extremes");
    set_vals(0, 16); stereo_frame(16, 1'b1, "R3 R7 LJ 16-bit random");
    drain("R8 LJ drained");

    // R7: reserved length code treated as 24
    do_reset(3'd3, 2'b11);
    set_vals(0, 24); stereo_frame(24, 1'b1, "R7 LJ code 11 as 24-bit");
    drain("R7 code 11 drained");

    // R4: right-justified 24 and 16 bits
    do_reset(3'd1, 2'b00);
    set_vals(1, 24); stereo_frame(24, 1'b1, "R4 RJ 24-bit extremes");
    set_vals(0, 24); stereo_frame(24, 1'b1, "R4 RJ 24-bit random");
    drain("R8 RJ 24 drained");
    do_reset(3'd1, 2'b10);
    set_vals(0, 16); stereo_frame(16, 1'b1, "R4 R7 RJ 16-bit random");
    set_vals(1, 16); stereo_frame(16, 1'b1, "R4 R7 RJ 16-bit extremes");
    drain("R8 RJ 16 drained");

    // R5 R10: DSP with data valid only around the falling edge
    do_reset(3'd2, 2'b00);
    set_vals(1, 24); dsp_frame(24, 1'b1, "R5,R10 DSP 24-bit extremes");
    set_vals(0, 24); dsp_frame(24, 1'b1, "R5,R10 DSP 24-bit random");
    // lone left word, then reset: alternation must restart on left
    set_vals(0, 24); dsp_word(24, 0, 1'b1);
    drain("R5 lone word not reported");
    do_reset(3'd2, 2'b01);
    set_vals(0, 20); dsp_frame(20, 1'b1, "R5 DSP resync after reset");
    set_vals(1, 20); dsp_frame(20, 1'b1, "R5 R7 DSP 20-bit extremes");
    drain("R5 DSP drained");

    // R6 R10: packed format, noise on lanes 1 and 2
    do_reset(3'd4, 2'b00);
    set_vals(0, 24); tdm_frame(24, 1'b0, "");
    set_vals(1, 24); tdm_frame(24, 1'b1, "R6 packed 24-bit extremes");
    set_vals(0, 24); tdm_frame(24, 1'b1, "R6 packed 24-bit random");
    drain("R6 packed drained");
    do_reset(3'd4, 2'b01);
    set_vals(0, 20); tdm_frame(20, 1'b0, "");
    set_vals(0, 20); tdm_frame(20, 1'b1, "R6 R7 packed 20-bit random");
    drain("R6 packed 20 drained");

    // R9: reserved format ignores toggling stimulus
    do_reset(3'd6, 2'b00);
    set_vals(0, 24); stereo_frame(24, 1'b0, "");
    set_vals(0, 24); stereo_frame(24, 1'b0, "");
    idle(4);
    @(negedge sck);
    check(samples == '0 && frame_valid == 1'b0, "R9 reserved format silent",
          samples, '0);

    // R8: every expected frame was seen exactly once
    check(frames_seen == frames_pushed, "R8 frame count",
          144'(frames_seen), 144'(frames_pushed));
    finish_up();
  end

endmodule